// File: doc/BRIEF.md
# DMA Bus Ownership Mode Controller

This block moves a block of words from a source region to a destination region over a memory bus that it shares with a CPU. It uses single-word bus accesses. A transfer is started by a one-cycle start pulse. That pulse carries a source address, a destination address, a word count and an ownership mode. The block captures all of these values on the start pulse. Each word is moved as a read of the source followed by a write of the read data to the destination. Both accesses take place while the block holds the bus. Consecutive words use consecutive addresses.

The ownership mode sets when the block may take the bus:

- **Cycle stealing:** the block takes the bus for one word, gives it back, and arbitrates again for the next word.
- **Block burst:** the block keeps the bus from its first word until its last word, and the CPU waits.
- **Idle-only:** the block takes the bus only when the CPU signals that the bus is idle.

A CPU bus request always wins arbitration against a new grant. A burst that is already running is never interrupted. A one-cycle done pulse marks the end of every transfer, including an empty one.

Top module: `dma_bus_mode_ctrl`

## Requirements
- R1: After reset, `done`, `dma_own`, `dma_req` and `bus_valid` are all low.
- R2: Word i of a transfer is moved in two accesses within one ownership tenure. The first is a read at `src + i`. The second is a write of the read data to `dst + i`, for i = 0 to count-1. `bus_valid` is never high unless `dma_own` is high. An access that has not been accepted holds its address and direction until `bus_ready` is high.
- R3: Mode code 0 (cycle stealing) works one word per tenure. In the cycle after each word's write is accepted, `dma_own` is low, and the block then requests the bus again for the next word. Mode code 3 behaves the same as code 0. A transfer of N words therefore has N ownership tenures.
- R4: Mode code 1 (block burst) holds `dma_own` high without a break from the first read to the last write, whatever `cpu_req` does during that time. A burst transfer has exactly one tenure.
- R5: Mode code 2 (idle-only) takes ownership only at a clock edge where `cpu_idle` = 1 and `cpu_req` = 0.
- R6: In every mode, ownership is never taken at a clock edge where `cpu_req` = 1. While `cpu_req` stays high, `dma_own` stays low.
- R7: The mode, addresses and count are captured on `start`. Changes to the `cfg_*` inputs, and further `start` pulses, during a transfer have no effect on that transfer.
- R8: `done` is high for exactly one cycle, in the cycle after the final write is accepted. In that cycle `dma_own` and `dma_req` are low.
- R9: A start with a count of 0 raises `done` in the following cycle and never raises `dma_req` or `bus_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer start pulse |
| cfg_mode | input | 2 | Ownership mode: 0 stealing, 1 burst, 2 idle-only, 3 same as 0 |
| cfg_src | input | AW | Source start word address |
| cfg_dst | input | AW | Destination start word address |
| cfg_count | input | CW | Number of words to move |
| cpu_req | input | 1 | CPU wants the bus; has priority at grant |
| cpu_idle | input | 1 | CPU hint that it is not using the bus this cycle |
| dma_req | output | 1 | Block is waiting to take the bus |
| dma_own | output | 1 | Block currently owns the bus |
| bus_valid | output | 1 | Bus access valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Word address of the access |
| bus_wdata | output | DW | Write data |
| bus_ready | input | 1 | Memory accepts the access this cycle |
| bus_rdata | input | DW | Read data, valid while a read is accepted |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest situations to reach from the ports are the ones where the CPU contends with the block at the moment of arbitration. Two cases matter most. One is a CPU request that arrives in the middle of a burst. The other is an idle hint that switches on and off while an idle-only transfer is re-arbitrating between words. The bench reaches these cases by running the CPU signals in parallel branches against a running transfer. It raises `cpu_req` a few cycles after the burst is granted. It holds `cpu_req` high across the start of a cycle-stealing transfer. It drives `cpu_idle` with an irregular on/off pattern during an idle-only transfer. It also stalls `bus_ready` on alternate cycles, so that accesses must wait. A monitor records the CPU signals at every edge where ownership is taken. Another parallel branch changes every configuration input and pulses `start` again during a burst, to show that the captured values are the ones used.

// File: rtl/dma_mode_pkg.sv
package dma_mode_pkg;
  typedef enum logic [1:0] {
    MODE_STEAL     = 2'd0,
    MODE_BURST     = 2'd1,
    MODE_IDLE_ONLY = 2'd2,
    MODE_RSVD      = 2'd3
  } dma_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/dma_own_policy.sv
module dma_own_policy
  import dma_mode_pkg::*;
(
  input  dma_mode_e mode,
  input  logic      cpu_req,
  input  logic      cpu_idle,
  output logic      may_take,
  output logic      hold_tenure
);
  always_comb begin
    unique case (mode)
      MODE_IDLE_ONLY: may_take = cpu_idle && !cpu_req;
      default:        may_take = !cpu_req;
    endcase
    hold_tenure = (mode == MODE_BURST);
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_src,
  input  logic [AW-1:0] load_dst,
  input  logic [CW-1:0] load_cnt,
  input  logic          step,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [AW-1:0] src_next,
  output logic          last
);
  localparam logic [CW-1:0] ONE_WORD = CW'(1);

  logic [CW-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr  <= '0;
      dst_addr  <= '0;
      remaining <= '0;
    end else if (load) begin
      src_addr  <= load_src;
      dst_addr  <= load_dst;
      remaining <= load_cnt;
    end else if (step) begin
      src_addr  <= src_addr + AW'(1);
      dst_addr  <= dst_addr + AW'(1);
      remaining <= remaining - ONE_WORD;
    end
  end

  assign src_next = src_addr + AW'(1);
  assign last     = (remaining == ONE_WORD);
endmodule

// File: rtl/dma_word_buf.sv
module dma_word_buf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (capture) dout <= din;
  end
endmodule

// File: rtl/dma_bus_mode_ctrl.sv
module dma_bus_mode_ctrl
  import dma_mode_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          cpu_req,
  input  logic          cpu_idle,
  output logic          dma_req,
  output logic          dma_own,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          done
);
  xfer_state_e   state;
  dma_mode_e     mode_q;
  logic          may_take;
  logic          hold_tenure;
  logic          load;
  logic          step;
  logic          last;
  logic [AW-1:0] src_addr;
  logic [AW-1:0] dst_addr;
  logic [AW-1:0] src_next;

  assign load = (state == ST_IDLE) && start && (cfg_count != '0);
  assign step = (state == ST_WR) && bus_ready;

  dma_own_policy i_policy (
    .mode        (mode_q),
    .cpu_req     (cpu_req),
    .cpu_idle    (cpu_idle),
    .may_take    (may_take),
    .hold_tenure (hold_tenure)
  );

  dma_addr_seq #(.AW(AW), .CW(CW)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_src (cfg_src),
    .load_dst (cfg_dst),
    .load_cnt (cfg_count),
    .step     (step),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .src_next (src_next),
    .last     (last)
  );

  dma_word_buf #(.DW(DW)) i_buf (
    .clk     (clk),
    .rst     (rst),
    .capture ((state == ST_RD) && bus_ready),
    .din     (bus_rdata),
    .dout    (bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= MODE_STEAL;
      dma_req   <= 1'b0;
      dma_own   <= 1'b0;
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (cfg_count == '0) begin
              done <= 1'b1;
            end else begin
              mode_q  <= dma_mode_e'(cfg_mode);
              dma_req <= 1'b1;
              state   <= ST_ARB;
            end
          end
        end
        ST_ARB: begin
          if (may_take) begin
            dma_req   <= 1'b0;
            dma_own   <= 1'b1;
            bus_valid <= 1'b1;
            bus_we    <= 1'b0;
            bus_addr  <= src_addr;
            state     <= ST_RD;
          end
        end
        ST_RD: begin
          if (bus_ready) begin
            bus_we   <= 1'b1;
            bus_addr <= dst_addr;
            state    <= ST_WR;
          end
        end
        ST_WR: begin
          if (bus_ready) begin
            bus_we <= 1'b0;
            if (last) begin
              bus_valid <= 1'b0;
              dma_own   <= 1'b0;
              done      <= 1'b1;
              state     <= ST_IDLE;
            end else if (hold_tenure) begin
              bus_addr <= src_next;
              state    <= ST_RD;
            end else begin
              bus_valid <= 1'b0;
              dma_own   <= 1'b0;
              dma_req   <= 1'b1;
              state     <= ST_ARB;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_bus_mode_ctrl_chk.sv
module dma_bus_mode_ctrl_chk
  import dma_mode_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req,
  input logic          cpu_idle,
  input logic          dma_req,
  input logic          dma_own,
  input logic          bus_valid,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ready,
  input logic          done,
  input dma_mode_e     mode_q
);
  p_valid_needs_own_r2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> dma_own);

  p_access_held_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));

  p_steal_release_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && bus_ready && (mode_q == MODE_STEAL || mode_q == MODE_RSVD))
      |=> !dma_own);

  p_burst_unbroken_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(dma_own) && mode_q == MODE_BURST) |-> done);

  p_idle_only_grant_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(dma_own) && mode_q == MODE_IDLE_ONLY) |-> ($past(cpu_idle) && !$past(cpu_req)));

  p_cpu_priority_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_own) |-> !$past(cpu_req));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_released_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!dma_own && !dma_req));
endmodule

bind dma_bus_mode_ctrl dma_bus_mode_ctrl_chk #(.AW(AW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_idle  (cpu_idle),
  .dma_req   (dma_req),
  .dma_own   (dma_own),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_ready (bus_ready),
  .done      (done),
  .mode_q    (mode_q)
);

// File: tb/test_dma_bus_mode_ctrl.sv
`timescale 1ns/1ps
module test_dma_bus_mode_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int MEMW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [AW-1:0] cfg_src = '0;
  logic [AW-1:0] cfg_dst = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          cpu_req = 1'b0;
  logic          cpu_idle = 1'b0;
  logic          stall = 1'b0;
  logic          dma_req, dma_own, bus_valid, bus_we, bus_ready, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  logic [DW-1:0] mem  [MEMW];
  logic [DW-1:0] orig [MEMW];

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int cyc = 0, n_rd = 0, n_wr = 0, rises = 0, bad_grant = 0, bad_idle = 0;
  int bad_seq = 0, req_seen = 0, done_pulses = 0, lastwr_cyc = -1, done_cyc = -1;
  int own_in_hold = 0;
  bit last_was_rd = 0, own_prev = 0, req_prev = 0, idle_prev = 0;
  logic [AW-1:0] rd_addr [64];
  logic [AW-1:0] wr_addr [64];

  always #2.5 clk = ~clk;

  assign bus_ready = bus_valid && !stall;
  assign bus_rdata = mem[bus_addr];

  dma_bus_mode_ctrl #(.AW(AW), .DW(DW), .CW(CW)) i_dma_bus_mode_ctrl (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cpu_req(cpu_req), .cpu_idle(cpu_idle),
    .dma_req(dma_req), .dma_own(dma_own), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (bus_valid && bus_ready) begin
        if (bus_we) begin
          mem[bus_addr] <= bus_wdata;
          if (n_wr < 64) wr_addr[n_wr] = bus_addr;
          n_wr = n_wr + 1;
          lastwr_cyc = cyc;
          if (!last_was_rd) bad_seq = bad_seq + 1;
          last_was_rd = 0;
        end else begin
          if (n_rd < 64) rd_addr[n_rd] = bus_addr;
          n_rd = n_rd + 1;
          if (last_was_rd) bad_seq = bad_seq + 1;
          last_was_rd = 1;
        end
      end
      if (dma_own && !own_prev) begin
        rises = rises + 1;
        if (req_prev) bad_grant = bad_grant + 1;
        if (!idle_prev) bad_idle = bad_idle + 1;
      end
      if (dma_req) req_seen = req_seen + 1;
      if (done) begin
        done_pulses = done_pulses + 1;
        done_cyc = cyc;
      end
      if (dma_own && cpu_req) own_in_hold = own_in_hold + 1;
    end
    own_prev  = dma_own;
    req_prev  = cpu_req;
    idle_prev = cpu_idle;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_rd = 0; n_wr = 0; rises = 0; bad_grant = 0; bad_idle = 0; bad_seq = 0;
    req_seen = 0; done_pulses = 0; lastwr_cyc = -1; done_cyc = -1; last_was_rd = 0;
    own_in_hold = 0;
  endtask

  task automatic run_xfer(input logic [1:0] m, input int src, input int dst, input int cnt);
    int waited;
    @(negedge clk);
    clear_mon();
    cfg_mode = m; cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R8 done seen", int'(done), 1);
    check(dma_own == 1'b0 && dma_req == 1'b0, "R8 released at done",
          int'({dma_own, dma_req}), 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  task automatic check_copy(input string tag, input int src, input int dst, input int cnt);
    int bad = 0;
    check(n_rd == cnt && n_wr == cnt, {tag, " R2 access count"}, n_rd + n_wr, 2 * cnt);
    for (int i = 0; i < cnt; i++) begin
      if (rd_addr[i] != AW'(src + i) || wr_addr[i] != AW'(dst + i)) bad++;
      if (mem[dst + i] != orig[src + i]) bad++;
    end
    check(bad == 0, {tag, " R2 addresses and data"}, bad, 0);
    check(bad_seq == 0, {tag, " R2 read then write order"}, bad_seq, 0);
    check(done_cyc == lastwr_cyc + 1, {tag, " R8 done after last write"},
          done_cyc - lastwr_cyc, 1);
    check(done_pulses == 1, {tag, " R8 single pulse"}, done_pulses, 1);
    check(bad_grant == 0, {tag, " R6 no grant under cpu_req"}, bad_grant, 0);
  endtask

  task automatic t_reset();
    check(done == 0 && dma_own == 0 && dma_req == 0 && bus_valid == 0, "R1 reset state",
          int'({done, dma_own, dma_req, bus_valid}), 0);
  endtask

  task automatic t_burst();
    fork
      run_xfer(2'd1, 16, 100, 8);
      begin
        repeat (5) @(negedge clk);
        cpu_req = 1'b1;
      end
    join
    cpu_req = 1'b0;
    check_copy("burst", 16, 100, 8);
    check(rises == 1, "R4 one tenure in burst", rises, 1);
    check(own_in_hold > 0, "R4 burst kept bus under cpu_req", own_in_hold, 1);
  endtask

  task automatic t_steal();
    bit stop = 0;
    fork
      begin
        run_xfer(2'd0, 30, 120, 5);
        stop = 1;
      end
      begin
        while (!stop) begin
          @(negedge clk);
          stall = ~stall;
        end
        stall = 1'b0;
      end
    join
    check_copy("steal", 30, 120, 5);
    check(rises == 5, "R3 one tenure per word", rises, 5);
  endtask

  task automatic t_priority();
    int own_seen = 0;
    fork
      run_xfer(2'd3, 40, 140, 3);
      begin
        cpu_req = 1'b1;
        repeat (20) begin
          @(negedge clk);
          if (dma_own) own_seen++;
        end
        check(own_seen == 0, "R6 no ownership while cpu_req held", own_seen, 0);
        cpu_req = 1'b0;
      end
    join
    check_copy("prio", 40, 140, 3);
    check(rises == 3, "R3 code 3 acts as stealing", rises, 3);
  endtask

  task automatic t_idle_only();
    bit stop = 0;
    fork
      begin
        run_xfer(2'd2, 50, 160, 4);
        stop = 1;
      end
      begin
        int k = 0;
        while (!stop) begin
          @(negedge clk);
          cpu_idle = (k % 7 == 3) || (k % 11 == 5);
          k++;
        end
        cpu_idle = 1'b0;
      end
    join
    check_copy("idle", 50, 160, 4);
    check(bad_idle == 0, "R5 grant only when cpu idle", bad_idle, 0);
  endtask

  task automatic t_latch();
    fork
      run_xfer(2'd1, 60, 180, 4);
      begin
        repeat (3) @(negedge clk);
        cfg_src = AW'(200); cfg_dst = AW'(220); cfg_count = CW'(9); cfg_mode = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    check_copy("latch", 60, 180, 4);
    check(rises == 1, "R7 captured mode kept", rises, 1);
    check(mem[220] == orig[220], "R7 new dst untouched", int'(mem[220]), int'(orig[220]));
  endtask

  task automatic t_zero();
    int vis = 0;
    @(negedge clk);
    clear_mon();
    cfg_count = '0; cfg_mode = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R9 done after zero start", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    vis = req_seen + n_rd + n_wr;
    check(vis == 0, "R9 no bus request for zero count", vis, 0);
  endtask

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      mem[i]  = DW'(i * 37 + 5);
      orig[i] = DW'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_burst();
    t_steal();
    t_priority();
    t_idle_only();
    t_latch();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule